// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block performs one-bit-per-step division on a remainder register and a divisor, following a three-flag protocol. Flag Q carries the partial-remainder sign history. Flag M holds the divisor sign. Flag T is the quotient bit produced by each step. Before stepping, software-visible flows choose either a signed or an unsigned initialise operation, which prepares the flags. Each later step shifts T into the remainder and then adds or subtracts the divisor, depending on whether Q and M agree. The new Q comes from the carry or borrow of that operation.

Two ways of stepping are offered. A single step takes its remainder and divisor from the operand inputs, as one instruction would. An iterative run loads both operands and then performs a fixed number of steps back to back, one per clock. During the run, the T bit of every step is collected into a quotient register. Handling the low half of a double-width dividend is left to the surrounding logic.

Top module: `divstep_unit`

## Requirements
- R1: While reset is high and after it is released, rem_out, quo_out, q_out, m_out, t_out, busy and done are all 0.
- R2: A start with op = 2'b01 (signed initialise) sets Q to opa[31], M to opb[31] and T to Q XOR M, and loads rem_out with opa.
- R3: A start with op = 2'b00 (unsigned initialise) clears Q, M and T and loads rem_out with opa.
- R4: A start with op = 2'b10 (single step) forms shifted = {opa[30:0], T}. It computes shifted minus opb when the old Q equals M, and shifted plus opb otherwise. rem_out takes that result.
- R5: In a step, let c be the borrow of a subtraction (result greater than shifted) or the carry of an addition (result less than shifted). When M is 0 the new Q is the pre-shift MSB XOR c. When M is 1 it is the inverted pre-shift MSB XOR c.
- R6: After every step, T is 1 exactly when the new Q equals M.
- R7: Initialise and single-step operations complete at the clock edge that samples start. done is high for exactly the following cycle, and busy stays 0.
- R8: A start with op = 2'b11 (iterative run) loads opa as the remainder and opb as the divisor, and clears quo_out. busy is high from the next cycle. 32 steps follow, one per clock. busy falls and done rises together, directly after the 32nd step.
- R9: During a run, the T of each step enters quo_out at bit 0, and the earlier bits shift up. The first step's T ends at bit 31.
- R10: A start that arrives while busy is high is ignored. The run's final remainder, quotient and flags equal those of an uninterrupted run.
- R11: Steps and runs use the flags left by the previous operation. A single step leaves quo_out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, sampled at the rising edge |
| op | input | 2 | Command: 00 unsigned init, 01 signed init, 10 step, 11 run |
| opa | input | 32 | Remainder / dividend operand |
| opb | input | 32 | Divisor operand |
| rem_out | output | 32 | Current remainder register |
| quo_out | output | 32 | Quotient collected during a run |
| q_out | output | 1 | Flag Q |
| m_out | output | 1 | Flag M |
| t_out | output | 1 | Flag T |
| busy | output | 1 | Iterative run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A new command strobe can coincide with a step of an iterative run that is in progress. In that cycle the block must keep stepping, and must not reload operands or flags. The bench provokes this by pulsing start with a signed initialise carrying unrelated operands a few cycles into a run. It then judges the outcome by comparing the final remainder, quotient and flags with a model run that had no interruption, and by checking that done still lands exactly after the 32nd step.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

    typedef enum logic [1:0] {
        OP_UINIT = 2'b00,
        OP_SINIT = 2'b01,
        OP_STEP  = 2'b10,
        OP_RUN   = 2'b11
    } divop_e;

    typedef struct packed {
        logic q;
        logic m;
        logic t;
    } divflags_t;

    function automatic divflags_t signed_init(input logic rem_msb, input logic div_msb);
        divflags_t f;
        f.q = rem_msb;
        f.m = div_msb;
        f.t = rem_msb ^ div_msb;
        return f;
    endfunction

endpackage

// File: rtl/divstep_alu.sv
module divstep_alu
    import divstep_pkg::*;
#(
    parameter int  W            = 32,
    parameter bit  SHARED_ADDER = 1'b1
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] div_i,
    input  divflags_t    flags_i,
    output logic [W-1:0] rem_o,
    output divflags_t    flags_o
);
    logic [W-1:0] shifted;
    logic [W-1:0] result;
    logic         do_sub;
    logic         cy;
    logic         q_pre;

    assign shifted = {rem_i[W-2:0], flags_i.t};
    assign do_sub  = (flags_i.q == flags_i.m);
    assign q_pre   = rem_i[W-1];

    generate
        if (SHARED_ADDER) begin : g_shared
            logic [W-1:0] operand;
            assign operand = do_sub ? ~div_i : div_i;
            assign result  = shifted + operand + {{(W-1){1'b0}}, do_sub};
        end else begin : g_split
            logic [W-1:0] diff;
            logic [W-1:0] sum;
            assign diff   = shifted - div_i;
            assign sum    = shifted + div_i;
            assign result = do_sub ? diff : sum;
        end
    endgenerate

    assign cy = do_sub ? (result > shifted) : (result < shifted);

    always_comb begin
        flags_o.m = flags_i.m;
        flags_o.q = flags_i.m ? (~q_pre ^ cy) : (q_pre ^ cy);
        flags_o.t = (flags_o.q == flags_i.m);
        rem_o     = result;
    end

endmodule

// File: rtl/divstep_ctrl.sv
module divstep_ctrl
    import divstep_pkg::*;
#(
    parameter int STEPS = 32
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  divop_e op,
    output logic   fire_uinit,
    output logic   fire_sinit,
    output logic   fire_step,
    output logic   fire_load,
    output logic   run_step,
    output logic   busy,
    output logic   done
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    logic          accept;
    logic          last;
    logic [CW-1:0] cnt;

    assign accept     = start && !busy;
    assign fire_uinit = accept && (op == OP_UINIT);
    assign fire_sinit = accept && (op == OP_SINIT);
    assign fire_step  = accept && (op == OP_STEP);
    assign fire_load  = accept && (op == OP_RUN);
    assign run_step   = busy;
    assign last       = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= fire_uinit || fire_sinit || fire_step || (busy && last);
            if (fire_load) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
                if (last) busy <= 1'b0;
            end
        end
    end

    // R8: a run keeps going until its final step
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> busy);

    // R8: the end of a run coincides with the done pulse
    p_done_end_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && last) |=> (!busy && done));

    // R10: a start during a run only advances the step count
    p_ignore_start_r10: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !last) |=> (busy && cnt == $past(cnt) + 1'b1));

    // R7: single operations finish in one edge
    p_single_done_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op != OP_RUN) |=> (done && !busy));

endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
    import divstep_pkg::*;
#(
    parameter int W     = 32,
    parameter int STEPS = W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out,
    output logic         q_out,
    output logic         m_out,
    output logic         t_out,
    output logic         busy,
    output logic         done
);
    divop_e       op_e;
    logic         fire_uinit, fire_sinit, fire_step, fire_load, run_step;
    logic [W-1:0] rem_q, div_q, quo_q;
    divflags_t    flags_q;
    logic [W-1:0] alu_rem_in, alu_div_in, alu_rem_out;
    divflags_t    alu_flags_out;

    assign op_e = divop_e'(op);

    divstep_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op         (op_e),
        .fire_uinit (fire_uinit),
        .fire_sinit (fire_sinit),
        .fire_step  (fire_step),
        .fire_load  (fire_load),
        .run_step   (run_step),
        .busy       (busy),
        .done       (done)
    );

    assign alu_rem_in = fire_step ? opa : rem_q;
    assign alu_div_in = fire_step ? opb : div_q;

    divstep_alu #(.W(W), .SHARED_ADDER(1'b1)) u_alu (
        .rem_i   (alu_rem_in),
        .div_i   (alu_div_in),
        .flags_i (flags_q),
        .rem_o   (alu_rem_out),
        .flags_o (alu_flags_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= '0;
            div_q   <= '0;
            quo_q   <= '0;
            flags_q <= '0;
        end else if (fire_uinit) begin
            rem_q   <= opa;
            div_q   <= opb;
            flags_q <= '0;
        end else if (fire_sinit) begin
            rem_q   <= opa;
            div_q   <= opb;
            flags_q <= signed_init(opa[W-1], opb[W-1]);
        end else if (fire_step) begin
            rem_q   <= alu_rem_out;
            div_q   <= opb;
            flags_q <= alu_flags_out;
        end else if (fire_load) begin
            rem_q <= opa;
            div_q <= opb;
            quo_q <= '0;
        end else if (run_step) begin
            rem_q   <= alu_rem_out;
            flags_q <= alu_flags_out;
            quo_q   <= {quo_q[W-2:0], alu_flags_out.t};
        end
    end

    assign rem_out = rem_q;
    assign quo_out = quo_q;
    assign q_out   = flags_q.q;
    assign m_out   = flags_q.m;
    assign t_out   = flags_q.t;

    // R2: signed initialise takes both sign bits
    p_sinit_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == 2'b01) |=>
            (q_out == $past(opa[W-1]) && m_out == $past(opb[W-1]) && t_out == (q_out ^ m_out)));

    // R3: unsigned initialise clears the flags
    p_uinit_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == 2'b00) |=> (!q_out && !m_out && !t_out));

    // R6: after any step T reports Q == M
    p_t_rule_r6: assert property (@(posedge clk) disable iff (rst)
        ((start && !busy && op == 2'b10) || busy) |=> (t_out == (q_out == m_out)));

    // R9: the newest quotient bit is the step's T
    p_quo_shift_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> (quo_out[0] == t_out && quo_out[W-1:1] == $past(quo_out[W-2:0])));

    // R11: a single step leaves the quotient alone
    p_step_quo_r11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == 2'b10) |=> $stable(quo_out));

endmodule

// File: tb/divstep_unit_test.sv
module divstep_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  op;
    logic [31:0] opa, opb;
    logic [31:0] rem_out, quo_out;
    logic        q_out, m_out, t_out, busy, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [31:0] mrem, mquo;
    logic        mq, mm, mt;

    always #5 clk = ~clk;

    divstep_unit uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
        .rem_out(rem_out), .quo_out(quo_out), .q_out(q_out), .m_out(m_out),
        .t_out(t_out), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // independent reference: 33-bit arithmetic gives the carry / borrow
    task automatic model_step(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] sh;
        logic [32:0] s;
        logic        nq;
        sh = {a[30:0], mt};
        if (mq == mm) s = {1'b0, sh} - {1'b0, b};
        else          s = {1'b0, sh} + {1'b0, b};
        nq   = a[31] ^ s[32] ^ mm;
        mrem = s[31:0];
        mq   = nq;
        mt   = (nq == mm);
    endtask

    task automatic chk_state(input string req);
        chk({req, " rem"}, rem_out, mrem);
        chk({req, " flags"}, {29'd0, q_out, m_out, t_out}, {29'd0, mq, mm, mt});
    endtask

    task automatic do_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start = 1'b1; op = o; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        case (o)
            2'b00: begin mrem = a; mq = 0; mm = 0; mt = 0; end
            2'b01: begin mrem = a; mq = a[31]; mm = b[31]; mt = a[31] ^ b[31]; end
            default: model_step(a, b);
        endcase
        if (o == 2'b00)      chk_state("R3");
        else if (o == 2'b01) chk_state("R2");
        else                 chk_state("R4 R5 R6");
        if (o == 2'b10) chk("R11 quo kept", quo_out, mquo);
        chk("R7 done/busy", {30'd0, done, busy}, 32'd2);
        @(negedge clk);
        chk("R7 done one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic do_run(input logic [31:0] a, input logic [31:0] b, input bit intr);
        @(negedge clk);
        start = 1'b1; op = 2'b11; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after load", {31'd0, busy}, 32'd1);
        chk("R8 quo cleared", quo_out, 32'd0);
        mrem = a; mquo = 32'd0;
        for (int i = 0; i < 32; i++) begin
            model_step(mrem, b);
            mquo = {mquo[30:0], mt};
        end
        for (int k = 1; k <= 31; k++) begin
            if (intr && k == 5) begin
                start = 1'b1; op = 2'b01; opa = ~a; opb = ~b;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R8 still busy before last", {30'd0, busy, done}, 32'd2);
        @(negedge clk);
        chk("R8 done at end", {30'd0, busy, done}, 32'd1);
        if (intr) begin
            chk("R10 rem", rem_out, mrem);
            chk("R10 quo", quo_out, mquo);
            chk("R10 flags", {29'd0, q_out, m_out, t_out}, {29'd0, mq, mm, mt});
        end else begin
            chk_state("R8 R11");
            chk("R9 quotient", quo_out, mquo);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] ra, rb;
        void'($urandom(32'd1234));
        rst = 1'b1; start = 1'b0; op = 2'b00; opa = '0; opb = '0;
        mrem = 0; mquo = 0; mq = 0; mm = 0; mt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset rem/quo", rem_out | quo_out, 32'd0);
        chk("R1 reset flags", {27'd0, q_out, m_out, t_out, busy, done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {27'd0, q_out, m_out, t_out, busy, done}, 32'd0);

        // directed corners
        do_op(2'b01, 32'h8000_0000, 32'h0000_0001);
        do_op(2'b10, 32'h8000_0000, 32'h0000_0001);
        do_op(2'b00, 32'hFFFF_FFFF, 32'h0);
        do_op(2'b10, 32'hFFFF_FFFF, 32'h0);
        do_op(2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        do_op(2'b10, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        do_op(2'b10, 32'h0000_0000, 32'h8000_0000);
        do_op(2'b00, 32'h0, 32'h0);
        do_run(32'h0000_0000, 32'h0000_0007, 1'b0);
        do_run(32'h1234_5678, 32'h0000_0000, 1'b0);

        // random mix
        for (int n = 0; n < 60; n++) begin
            ra = $urandom; rb = $urandom;
            do_op(($urandom % 2 == 0) ? 2'b00 : 2'b01, ra, rb);
            for (int s = 0; s < 3; s++) begin
                do_op(2'b10, $urandom, rb);
            end
        end
        for (int n = 0; n < 6; n++) begin
            ra = $urandom; rb = $urandom;
            do_op(n[0] ? 2'b01 : 2'b00, ra, rb);
            do_run(ra, rb, n >= 4);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule